// File: doc/BRIEF.md
# Masked Component Register File with Decoder Commit

This block is the 32-bit memory-mapped register file of a memory-interconnect component. It holds three things. The first is a capability header array that tells software which register groups exist and where they sit. The second is an error-reporting group with uncorrectable and correctable mask, severity and status words. The third is a bank of host-managed memory decoder registers.

Every 4-byte write is merged against a fixed per-register write mask, so read-only bits keep the value they already hold. Software programs a decoder and then sets its commit bit. The block acknowledges this in the same write: the stored control word comes back with commit cleared and the committed flag set.

The parameter `COMP_KIND` selects the component type:

| `COMP_KIND` | Component type | Headers | Decoder bank |
|---|---|---|---|
| 0 | downstream port | 2 | absent |
| 1 | plain device | 2 | absent |
| 2 | upstream port | 3 | present |
| 3 | memory-expander device | 3 | present |
| 4 | logical device | 3 | present |
| 5 | root port | 5 | present |

Types 1, 3 and 4 count as device types; all others are port types. A read request is answered one cycle later on `rsp_valid`/`rsp_rdata`. A malformed request is answered one cycle later by a one-cycle `rsp_err` pulse.

Top module: `cmp_regfile`

## Requirements
- R1: A well-formed 4-byte read (`req_size`=2, address bits [1:0] zero) returns the stored word on `rsp_rdata`, with `rsp_valid` high, exactly one cycle after the request.
- R2: An 8-byte access (`req_size`=3, aligned) is serviced as follows:
  - a read returns zero with `rsp_valid` high one cycle later;
  - a write changes nothing.
- R3: A request with address bits [1:0] nonzero, or with `req_size` 0 or 1, gives:
  - a one-cycle `rsp_err` pulse in the next cycle;
  - no `rsp_valid`;
  - no change to any stored word.
- R4: A 4-byte write stores (wdata AND mask) OR (old AND NOT mask). The error group's masks are 0x1CFFF at offsets 0x104 (uncorrectable mask) and 0x108 (uncorrectable severity), and 0x7F at offset 0x110 (correctable mask).
- R5: Decoder control (offset 0x320 for decoder 0) uses bit 9 as commit, bit 10 as committed and bit 11 as error. When the merged word has bit 9 set, the stored word has bits 9 and 11 cleared and bit 10 set. Bit 10 is never cleared by a write.
- R6: Decoder write masks, with decoder i at offset 0x310 + 0x20·i, are:
  - base-low (+0x0) and size-low (+0x8): 0xF0000000;
  - base-high (+0x4), size-high (+0xC) and target-list-high (+0x18): 0xFFFFFFFF;
  - control (+0x10): 0x13FF;
  - global decoder control at 0x304: 0x3.
  All of these reset to zero.
- R7: Target-list-low (+0x14) has mask 0xF0000000 on device types and 0xFFFFFFFF on port types.
- R8: The error group resets as follows:
  - uncorrectable mask and severity: 0x1CFFF;
  - correctable mask: 0x7F;
  - status words (0x100, 0x10C) and the capability/control word (0x114): 0, and they cannot be written.
- R9: The header at offset 0 reads ID 1 in [15:0], version 1 in [19:16] and cache-mem version 1 in [23:20]. Its [31:24] holds the array size: 2, 3 or 5 by type. The header is not writable.
- R10: Sub-headers sit at 0x4·n for n = 1..array size. Each carries ID in [15:0], version in [19:16] and register offset in [31:20]. In order, n = 1..5 are:
  - error group (2, 2, 0x100);
  - link (4, 2, 0x200);
  - decoder (5, 1, 0x300);
  - extended security (6, 1, 0x400);
  - snoop (8, 1, 0x500).
  Headers beyond the array size read zero.
- R11: The decoder capability word at 0x300 reads:
  - encoded decoder count in [3:0] (0 for one decoder);
  - target count 1 in [7:4];
  - 256-byte interleave support 1 in bit 8;
  - 4 KiB interleave support 1 in bit 9;
  - poison-on-error capability 0 in bit 10.
- R12: On types without the decoder bank, offsets 0x300–0x3FC read zero and ignore writes.
- R13: Unmapped offsets, the link and security regions included, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a serviced read |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | One-cycle pulse for a malformed request |

## Verification
The assertions take for granted that a request is presented for a single cycle with all its fields valid together. They also assume `req_valid` is low while reset is asserted and while the internal reset is being released. The stimulus drives every request on the falling clock edge for exactly one cycle. It then returns `req_valid` to zero and issues nothing until several cycles after reset deassertion. Malformed sizes and offsets are driven only as complete requests, never as partial updates of a request in flight.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  // component kinds
  localparam int KIND_DSP = 0;
  localparam int KIND_DEV = 1;
  localparam int KIND_USP = 2;
  localparam int KIND_T3  = 3;
  localparam int KIND_LD  = 4;
  localparam int KIND_RP  = 5;

  // register group placement
  localparam int RAS_OFS    = 'h100;
  localparam int LINK_OFS   = 'h200;
  localparam int HDM_OFS    = 'h300;
  localparam int XSEC_OFS   = 'h400;
  localparam int SNOOP_OFS  = 'h500;
  localparam int DEC_FIRST  = 'h10;
  localparam int DEC_STRIDE = 'h20;
  localparam int DEC_NREG   = 7;

  // write masks
  localparam logic [31:0] UNC_WM  = 32'h0001_CFFF;
  localparam logic [31:0] COR_WM  = 32'h0000_007F;
  localparam logic [31:0] GCTL_WM = 32'h0000_0003;
  localparam logic [31:0] LO_WM   = 32'hF000_0000;
  localparam logic [31:0] FULL_WM = 32'hFFFF_FFFF;
  localparam logic [31:0] CTRL_WM = 32'h0000_13FF;

  localparam int CTRL_COMMIT = 9;
  localparam int CTRL_DONE   = 10;
  localparam int CTRL_ERR    = 11;

  function automatic int caps_of(input int kind);
    case (kind)
      KIND_DSP, KIND_DEV:         return 2;
      KIND_USP, KIND_T3, KIND_LD: return 3;
      default:                    return 5;
    endcase
  endfunction

  function automatic bit is_device(input int kind);
    return (kind == KIND_DEV) || (kind == KIND_T3) || (kind == KIND_LD);
  endfunction

  function automatic logic [31:0] wmerge(input logic [31:0] wd,
                                         input logic [31:0] old,
                                         input logic [31:0] m);
    return (wd & m) | (old & ~m);
  endfunction

  function automatic logic [3:0] dec_count_enc(input int n);
    return (n <= 1) ? 4'd0 : 4'(n / 2);
  endfunction

  // per-decoder register k write mask
  function automatic logic [31:0] dec_wmask(input int k, input bit dev);
    case (k)
      0, 2:    return LO_WM;
      4:       return CTRL_WM;
      5:       return dev ? LO_WM : FULL_WM;
      default: return FULL_WM;
    endcase
  endfunction

endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/cmp_cap_hdr.sv
module cmp_cap_hdr
  import cmp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COMP_KIND = KIND_T3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [31:0]       rdata
);

  localparam int NCAP = caps_of(COMP_KIND);

  function automatic logic [31:0] sub_hdr(input int idx);
    case (idx)
      1:       return {12'(RAS_OFS),   4'd2, 16'd2};
      2:       return {12'(LINK_OFS),  4'd2, 16'd4};
      3:       return {12'(HDM_OFS),   4'd1, 16'd5};
      4:       return {12'(XSEC_OFS),  4'd1, 16'd6};
      5:       return {12'(SNOOP_OFS), 4'd1, 16'd8};
      default: return 32'd0;
    endcase
  endfunction

  always_comb begin
    rdata = 32'd0;
    if (addr == '0) begin
      rdata = {8'(NCAP), 4'd1, 4'd1, 16'd1};
    end
    for (int i = 1; i <= 5; i++) begin
      if ((i <= NCAP) && (addr == ADDR_W'(4 * i))) begin
        rdata = sub_hdr(i);
      end
    end
  end

endmodule

// File: rtl/cmp_ras_grp.sv
module cmp_ras_grp
  import cmp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] A_UNC_STAT = ADDR_W'(RAS_OFS + 'h00);
  localparam logic [ADDR_W-1:0] A_UNC_MASK = ADDR_W'(RAS_OFS + 'h04);
  localparam logic [ADDR_W-1:0] A_UNC_SEV  = ADDR_W'(RAS_OFS + 'h08);
  localparam logic [ADDR_W-1:0] A_COR_STAT = ADDR_W'(RAS_OFS + 'h0C);
  localparam logic [ADDR_W-1:0] A_COR_MASK = ADDR_W'(RAS_OFS + 'h10);
  localparam logic [ADDR_W-1:0] A_CAP_CTL  = ADDR_W'(RAS_OFS + 'h14);

  logic [31:0] unc_mask_q, unc_mask_d;
  logic [31:0] unc_sev_q,  unc_sev_d;
  logic [31:0] cor_mask_q, cor_mask_d;
  logic        unc_mask_en, unc_sev_en, cor_mask_en;

  // next-state
  always_comb begin
    unc_mask_en = wr_en && (addr == A_UNC_MASK);
    unc_sev_en  = wr_en && (addr == A_UNC_SEV);
    cor_mask_en = wr_en && (addr == A_COR_MASK);
    unc_mask_d  = wmerge(wdata, unc_mask_q, UNC_WM);
    unc_sev_d   = wmerge(wdata, unc_sev_q,  UNC_WM);
    cor_mask_d  = wmerge(wdata, cor_mask_q, COR_WM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unc_mask_q <= UNC_WM;
      unc_sev_q  <= UNC_WM;
      cor_mask_q <= COR_WM;
    end else begin
      if (unc_mask_en) unc_mask_q <= unc_mask_d;
      if (unc_sev_en)  unc_sev_q  <= unc_sev_d;
      if (cor_mask_en) cor_mask_q <= cor_mask_d;
    end
  end

  always_comb begin
    case (addr)
      A_UNC_MASK: rdata = unc_mask_q;
      A_UNC_SEV:  rdata = unc_sev_q;
      A_COR_MASK: rdata = cor_mask_q;
      A_UNC_STAT, A_COR_STAT, A_CAP_CTL: rdata = 32'd0;
      default:    rdata = 32'd0;
    endcase
  end

  AST_RAS_RESERVED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((unc_mask_q & ~UNC_WM) == ($past(unc_mask_q) & ~UNC_WM))); // R4

  AST_COR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cor_mask_en |=> ((cor_mask_q & ~COR_WM) == 32'd0)); // R8

endmodule

// File: rtl/cmp_hdm_grp.sv
module cmp_hdm_grp
  import cmp_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_DEC = 1,
  parameter bit PRESENT = 1'b1,
  parameter bit IS_DEV  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(HDM_OFS);
  localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(HDM_OFS + 'h04);
  localparam logic [31:0] CAP_WORD =
    {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, dec_count_enc(NUM_DEC)};

  logic        grp_we;
  logic [31:0] gctl_q, gctl_d;
  logic        gctl_en;
  logic [31:0] dec_rd  [NUM_DEC][DEC_NREG];
  logic        dec_hit [NUM_DEC][DEC_NREG];

  assign grp_we = PRESENT && wr_en;

  always_comb begin
    gctl_en = grp_we && (addr == A_GCTL);
    gctl_d  = wmerge(wdata, gctl_q, GCTL_WM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q <= 32'd0;
    end else if (gctl_en) begin
      gctl_q <= gctl_d;
    end
  end

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    for (genvar k = 0; k < DEC_NREG; k++) begin : g_reg
      localparam logic [ADDR_W-1:0] A_REG =
        ADDR_W'(HDM_OFS + DEC_FIRST + i * DEC_STRIDE + k * 4);
      localparam logic [31:0] WM = dec_wmask(k, IS_DEV);

      logic [31:0] reg_q, reg_d, merged;
      logic        reg_en;

      always_comb begin
        reg_en = grp_we && (addr == A_REG);
        merged = wmerge(wdata, reg_q, WM);
        reg_d  = merged;
        if ((k == 4) && merged[CTRL_COMMIT]) begin
          reg_d[CTRL_COMMIT] = 1'b0;
          reg_d[CTRL_ERR]    = 1'b0;
          reg_d[CTRL_DONE]   = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_q <= 32'd0;
        end else if (reg_en) begin
          reg_q <= reg_d;
        end
      end

      assign dec_rd[i][k]  = reg_q;
      assign dec_hit[i][k] = (addr == A_REG);

      if (k == 4) begin : g_ctl_chk
        AST_COMMIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
          (reg_en && wdata[CTRL_COMMIT]) |=>
            (reg_q[CTRL_DONE] && !reg_q[CTRL_COMMIT] && !reg_q[CTRL_ERR])); // R5

        AST_COMMITTED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
          reg_q[CTRL_DONE] |=> reg_q[CTRL_DONE]); // R5
      end
    end
  end

  always_comb begin
    rdata = 32'd0;
    if (PRESENT) begin
      if (addr == A_CAP)  rdata = CAP_WORD;
      if (addr == A_GCTL) rdata = gctl_q;
      for (int i = 0; i < NUM_DEC; i++) begin
        for (int k = 0; k < DEC_NREG; k++) begin
          if (dec_hit[i][k]) rdata = dec_rd[i][k];
        end
      end
    end
  end

endmodule

// File: rtl/cmp_regfile.sv
module cmp_regfile
  import cmp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COMP_KIND = KIND_T3,
  parameter int NUM_DEC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);

  localparam bit HAS_HDM = caps_of(COMP_KIND) >= 3;
  localparam bit DEV     = is_device(COMP_KIND);

  logic        rst_ni;
  logic        aligned, size_ok, good, bad, rd_go, wr4_go, is8;
  logic [31:0] cap_rd, ras_rd, hdm_rd;
  logic        valid_d, err_d;
  logic [31:0] rdata_d;
  logic        valid_q, err_q;
  logic [31:0] rdata_q;

  cmp_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  // request qualification
  always_comb begin
    aligned = (req_addr[1:0] == 2'b00);
    is8     = (req_size == SZ_8B);
    size_ok = (req_size == SZ_4B) || is8;
    good    = req_valid && aligned && size_ok;
    bad     = req_valid && !(aligned && size_ok);
    rd_go   = good && !req_we;
    wr4_go  = good && req_we && !is8;
  end

  cmp_cap_hdr #(
    .ADDR_W    (ADDR_W),
    .COMP_KIND (COMP_KIND)
  ) i_cap (
    .addr  (req_addr),
    .rdata (cap_rd)
  );

  cmp_ras_grp #(
    .ADDR_W (ADDR_W)
  ) i_ras (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr_en (wr4_go),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (ras_rd)
  );

  cmp_hdm_grp #(
    .ADDR_W  (ADDR_W),
    .NUM_DEC (NUM_DEC),
    .PRESENT (HAS_HDM),
    .IS_DEV  (DEV)
  ) i_hdm (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr_en (wr4_go),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (hdm_rd)
  );

  // response next-state
  always_comb begin
    valid_d = rd_go;
    err_d   = bad;
    rdata_d = is8 ? 32'd0 : (cap_rd | ras_rd | hdm_rd);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= 32'd0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (rd_go) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> $past(req_valid && !req_we)); // R1

  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_err |-> !rsp_valid); // R3

  AST_WIDE_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_we && aligned && is8) |=> (!rsp_err && !rsp_valid)); // R2

endmodule

// File: tb/test_cmp_regfile.sv
module test_cmp_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int KINDS [NI] = '{3, 5, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        o_valid [NI];
  logic        o_err   [NI];
  logic [31:0] o_rdata [NI];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string override_tag = "";

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmp_regfile #(.COMP_KIND(3)) i_cmp_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(o_valid[0]), .rsp_rdata(o_rdata[0]), .rsp_err(o_err[0]));

  cmp_regfile #(.COMP_KIND(5)) i_cmp_regfile_rp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(o_valid[1]), .rsp_rdata(o_rdata[1]), .rsp_err(o_err[1]));

  cmp_regfile #(.COMP_KIND(0)) i_cmp_regfile_dp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(o_valid[2]), .rsp_rdata(o_rdata[2]), .rsp_err(o_err[2]));

  // ---------------- reference model ----------------
  logic [31:0] st [int];
  logic        ev [NI];
  logic        ee [NI];
  logic [31:0] ed [NI];
  int          ea [NI];
  logic [1:0]  es [NI];

  function automatic bit m_hdm(input int kind);
    return kind >= 2;
  endfunction

  function automatic bit m_dev(input int kind);
    return (kind == 1) || (kind == 3) || (kind == 4);
  endfunction

  function automatic int m_caps(input int kind);
    if (kind <= 1) return 2;
    if (kind <= 4) return 3;
    return 5;
  endfunction

  function automatic logic [31:0] m_reset(input int kind, input int a);
    int ids [5] = '{2, 4, 5, 6, 8};
    int vers [5] = '{2, 2, 1, 1, 1};
    if (a == 0) return (32'(m_caps(kind)) << 24) | 32'h0011_0001;
    for (int n = 1; n <= 5; n++) begin
      if (a == 4 * n) begin
        if (n > m_caps(kind)) return 32'd0;
        return (32'(n * 'h100) << 20) | (32'(vers[n-1]) << 16) | 32'(ids[n-1]);
      end
    end
    if (a == 'h104 || a == 'h108) return 32'h1CFFF;
    if (a == 'h110) return 32'h7F;
    if (a == 'h300 && m_hdm(kind)) return 32'h0000_0310;
    return 32'd0;
  endfunction

  function automatic logic [31:0] m_mask(input int kind, input int a);
    if (a == 'h104 || a == 'h108) return 32'h1CFFF;
    if (a == 'h110) return 32'h7F;
    if (!m_hdm(kind)) return 32'd0;
    case (a)
      'h304: return 32'h3;
      'h310, 'h318: return 32'hF000_0000;
      'h314, 'h31C, 'h328: return 32'hFFFF_FFFF;
      'h320: return 32'h13FF;
      'h324: return m_dev(kind) ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] m_cur(input int k, input int a);
    int key = k * 4096 + a;
    if (st.exists(key)) return st[key];
    return m_reset(KINDS[k], a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      st.delete();
      for (int k = 0; k < NI; k++) begin
        ev[k] = 1'b0; ee[k] = 1'b0; ed[k] = '0; ea[k] = 0; es[k] = 2'd0;
      end
    end else begin
      for (int k = 0; k < NI; k++) begin
        bit ok;
        int a;
        logic [31:0] nv;
        a  = int'(req_addr);
        ok = req_valid && (req_addr[1:0] == 2'b00) && (req_size >= 2'd2);
        ee[k] = req_valid && !ok;
        ev[k] = ok && !req_we;
        if (ev[k]) begin
          ed[k] = (req_size == 2'd3) ? 32'd0 : m_cur(k, a);
          ea[k] = a;
          es[k] = req_size;
        end
        if (ok && req_we && req_size == 2'd2) begin
          nv = (req_wdata & m_mask(KINDS[k], a)) | (m_cur(k, a) & ~m_mask(KINDS[k], a));
          if (a == 'h320 && m_hdm(KINDS[k]) && nv[9]) begin
            nv[9] = 1'b0; nv[11] = 1'b0; nv[10] = 1'b1;
          end
          st[k * 4096 + a] = nv;
        end
      end
    end
  end

  function automatic string tag_of(input int k, input int a, input logic [1:0] sz);
    if (override_tag != "") return override_tag;
    if (sz == 2'd3) return "R2";
    if (!m_hdm(KINDS[k]) && a >= 'h300 && a < 'h400) return "R12";
    if (a == 0) return "R9";
    if (a < 'h100) return "R10";
    if (a == 'h104 || a == 'h108 || a == 'h110) return "R4";
    if (a >= 'h100 && a <= 'h114) return "R8";
    if (a == 'h300) return "R11";
    if (a == 'h320) return "R5";
    if (a == 'h324) return "R7";
    if (a >= 'h304 && a <= 'h328) return "R6";
    return "R13";
  endfunction

  task automatic check(input bit ok, input string tag, input int k,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s inst%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  // compare every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < NI; k++) begin
        check(o_valid[k] === ev[k], "R1", k, 32'(o_valid[k]), 32'(ev[k]));
        check(o_err[k] === ee[k], "R3", k, 32'(o_err[k]), 32'(ee[k]));
        if (ev[k]) check(o_rdata[k] === ed[k], tag_of(k, ea[k], es[k]), k, o_rdata[k], ed[k]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit we, input int a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = 12'(a); req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(input int a);
    issue(1'b0, a, 2'd2, 32'd0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    issue(1'b1, a, 2'd2, d);
  endtask

  localparam int NA = 26;
  localparam int ALIST [NA] = '{'h000, 'h004, 'h008, 'h00C, 'h010, 'h014, 'h018,
    'h100, 'h104, 'h108, 'h10C, 'h110, 'h114, 'h200, 'h300, 'h304, 'h310, 'h314,
    'h318, 'h31C, 'h320, 'h324, 'h328, 'h400, 'h800, 'hFFC};

  task automatic read_all();
    for (int i = 0; i < NA; i++) rd(ALIST[i]);
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state: R8 R9 R10 R11 R12 R13
    read_all();

    // all-ones then all-zeros writes: R4 R6 R7 R13
    for (int i = 0; i < NA; i++) wr(ALIST[i], 32'hFFFF_FFFF);
    read_all();
    for (int i = 0; i < NA; i++) wr(ALIST[i], 32'h0);
    read_all();

    // commit handshake: R5
    wr('h320, 32'h0000_0AAB);
    rd('h320);
    wr('h320, 32'h0000_0055);
    rd('h320);

    // wide accesses ignored / zero: R2
    override_tag = "R2";
    issue(1'b1, 'h314, 2'd3, 32'h1234_5678);
    issue(1'b1, 'h104, 2'd3, 32'h0);
    rd('h314);
    rd('h104);
    issue(1'b0, 'h104, 2'd3, 32'h0);

    // malformed requests leave state: R3
    override_tag = "R3";
    issue(1'b1, 'h316, 2'd2, 32'hFFFF_FFFF);
    issue(1'b1, 'h314, 2'd0, 32'hFFFF_FFFF);
    issue(1'b1, 'h110, 2'd1, 32'h0);
    issue(1'b0, 'h105, 2'd2, 32'h0);
    rd('h314);
    rd('h110);
    override_tag = "";

    // varied data patterns
    lfsr = 32'hACE1_1234;
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < NA; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3]) wr(ALIST[i], lfsr);
        else rd(ALIST[i]);
      end
    end
    read_all();

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule